// File: doc/BRIEF.md
# Register ALU With Carry Flag

This block is a register-to-register arithmetic and logic unit with sixteen 8-bit general registers, V0 to VF. The highest register, VF, also holds the carry, borrow or shifted-out bit of the flag-producing operations. On each clock edge with `en` high, the unit reads Vx and Vy and writes a result back to Vx. The registers are chosen by the 4-bit selectors `sel_x` and `sel_y`, and the operation by a command class and a 4-bit function code. It completes one operation per cycle.

Two further commands operate on one register and an immediate byte: loading the byte into Vx, and adding the byte to Vx. Any command or function code that is not defined leaves every register as it was and raises `err` for exactly one cycle. Two combinational read ports let a host or bench observe any register at any time.

Top module: `flag_alu`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears all sixteen registers to 0x00 and drives `err` low.
- R2: With `cmd`=2'b00, function codes 0x0, 0x1, 0x2 and 0x3 write Vy, Vx OR Vy, Vx AND Vy and Vx XOR Vy into Vx, and leave VF unchanged.
- R3: Function code 0x4 writes the low 8 bits of Vx+Vy into Vx, and writes 1 into VF when the sum exceeds 0xFF, otherwise 0.
- R4: Function code 0x5 writes (Vx-Vy) mod 256 into Vx, and writes 1 into VF only when Vx is strictly greater than Vy (equal operands give 0).
- R5: Function code 0x7 writes (Vy-Vx) mod 256 into Vx, and writes 1 into VF only when Vy is strictly greater than Vx.
- R6: Function code 0x6 shifts Vx right by one and writes the old bit 0 into VF. Function code 0xE shifts Vx left by one and writes the old bit 7 into VF. Vy has no effect on either.
- R7: When `sel_x` is 0xF and the operation writes a flag, VF ends up holding the flag value, not the arithmetic result.
- R8: `cmd`=2'b01 writes `imm` into Vx. `cmd`=2'b10 writes (Vx+`imm`) mod 256 into Vx and never writes VF on its own account.
- R9: `cmd`=2'b11, or `cmd`=2'b00 with a function code other than 0x0 to 0x7 or 0xE, changes no register. `err` goes high in the cycle after that edge and stays high for that one cycle only.
- R10: With `en` low, no register changes and `err` stays low.
- R11: `dbg_a_data` and `dbg_b_data` show the current contents of the registers named by `dbg_a_sel` and `dbg_b_sel` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Perform the command on this edge |
| cmd | input | 2 | Command class: 00 register op, 01 load immediate, 10 add immediate, 11 undefined |
| func | input | 4 | Function code for register ops |
| sel_x | input | 4 | Destination and first source register |
| sel_y | input | 4 | Second source register |
| imm | input | 8 | Immediate byte |
| dbg_a_sel | input | 4 | Debug read port A register select |
| dbg_a_data | output | 8 | Debug read port A data |
| dbg_b_sel | input | 4 | Debug read port B register select |
| dbg_b_data | output | 8 | Debug read port B data |
| err | output | 1 | One-cycle pulse after an undefined command |

## Verification
Each arithmetic code is driven with operand pairs on both sides of its flag boundary. For add, the sums are just below and just above 0xFF. For both subtractions, the operands are greater, equal and smaller, so a greater-or-equal compare is told apart from a strict one. The shifts use operands whose outgoing bit is 1 in one case and 0 in the other, and a Vy of 0xFF, so any leak of Vy shows up. A destination of VF separates the flag-wins ordering from the result-wins ordering. A wrapping immediate add with a preset VF separates a flag-free add from a carrying one.

// File: rtl/flag_alu_pkg.sv
// Package: shared encodings for the flag ALU.
// Assumes the 2-bit command class and the 4-bit function code described in the brief.
package flag_alu_pkg;

    typedef enum logic [1:0] {
        CMD_REG  = 2'b00,
        CMD_LDI  = 2'b01,
        CMD_ADDI = 2'b10,
        CMD_RSVD = 2'b11
    } cmd_e;

    typedef enum logic [3:0] {
        FN_MOV  = 4'h0,
        FN_OR   = 4'h1,
        FN_AND  = 4'h2,
        FN_XOR  = 4'h3,
        FN_ADD  = 4'h4,
        FN_SUB  = 4'h5,
        FN_SHR  = 4'h6,
        FN_RSUB = 4'h7,
        FN_SHL  = 4'hE
    } fn_e;

endpackage

// File: rtl/flag_alu_core.sv
// Module: flag_alu_core
// Purely combinational datapath. From the command, the function code, the two
// operands and the immediate it forms a result, a flag and their write strobes.
// Assumes the caller gates both strobes with its enable. Undefined codes assert
// `illegal` and leave both strobes low.
module flag_alu_core #(
    parameter int DW = 8
) (
    input  logic [1:0]    cmd,
    input  logic [3:0]    func,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] res,
    output logic          res_we,
    output logic [DW-1:0] flg,
    output logic          flg_we,
    output logic          illegal
);
    import flag_alu_pkg::*;

    logic [DW:0] sum_w;
    logic        flag_bit;

    // Full-width sum, with the carry kept in the top bit.
    assign sum_w = {1'b0, opa} + {1'b0, opb};
    // Widen the single flag bit to a register value.
    assign flg   = {{(DW-1){1'b0}}, flag_bit};

    // Decode the command and compute the result and flag.
    always_comb begin
        res      = '0;
        res_we   = 1'b0;
        flag_bit = 1'b0;
        flg_we   = 1'b0;
        illegal  = 1'b0;
        case (cmd_e'(cmd))
            CMD_LDI: begin
                res    = imm;
                res_we = 1'b1;
            end
            CMD_ADDI: begin
                res    = opa + imm;
                res_we = 1'b1;
            end
            CMD_REG: begin
                res_we = 1'b1;
                case (fn_e'(func))
                    FN_MOV:  res = opb;
                    FN_OR:   res = opa | opb;
                    FN_AND:  res = opa & opb;
                    FN_XOR:  res = opa ^ opb;
                    FN_ADD: begin
                        res      = sum_w[DW-1:0];
                        flag_bit = sum_w[DW];
                        flg_we   = 1'b1;
                    end
                    FN_SUB: begin
                        res      = opa - opb;
                        flag_bit = (opa > opb);
                        flg_we   = 1'b1;
                    end
                    FN_RSUB: begin
                        res      = opb - opa;
                        flag_bit = (opb > opa);
                        flg_we   = 1'b1;
                    end
                    FN_SHR: begin
                        res      = opa >> 1;
                        flag_bit = opa[0];
                        flg_we   = 1'b1;
                    end
                    FN_SHL: begin
                        res      = opa << 1;
                        flag_bit = opa[DW-1];
                        flg_we   = 1'b1;
                    end
                    default: begin
                        res_we  = 1'b0;
                        illegal = 1'b1;
                    end
                endcase
            end
            default: illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/flag_alu_regfile.sv
// Module: flag_alu_regfile
// NREG registers of DW bits, with four combinational read ports and two write
// ports: a result port at any address, and a flag port fixed to the top
// register. When both write ports hit the top register on one edge, the flag
// port wins. Reset is synchronous and active low.
module flag_alu_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_we,
    input  logic [AW-1:0] res_addr,
    input  logic [DW-1:0] res_data,
    input  logic          flg_we,
    input  logic [DW-1:0] flg_data,
    input  logic [AW-1:0] rd0_addr,
    output logic [DW-1:0] rd0_data,
    input  logic [AW-1:0] rd1_addr,
    output logic [DW-1:0] rd1_data,
    input  logic [AW-1:0] rd2_addr,
    output logic [DW-1:0] rd2_data,
    input  logic [AW-1:0] rd3_addr,
    output logic [DW-1:0] rd3_data
);
    localparam int FLAG_IDX = NREG - 1;

    logic [DW-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == FLAG_IDX) begin : g_flag
            // Flag register: the flag write takes priority over the result write.
            always_ff @(posedge clk) begin
                if (!rst_n)                              regs_q[g] <= '0;
                else if (flg_we)                         regs_q[g] <= flg_data;
                else if (res_we && res_addr == AW'(g))   regs_q[g] <= res_data;
            end
        end else begin : g_plain
            // Plain register: written only by the result port.
            always_ff @(posedge clk) begin
                if (!rst_n)                              regs_q[g] <= '0;
                else if (res_we && res_addr == AW'(g))   regs_q[g] <= res_data;
            end
        end
    end

    // Asynchronous read ports.
    assign rd0_data = regs_q[rd0_addr];
    assign rd1_data = regs_q[rd1_addr];
    assign rd2_data = regs_q[rd2_addr];
    assign rd3_data = regs_q[rd3_addr];

endmodule

// File: rtl/flag_alu.sv
// Module: flag_alu (top)
// Joins the register file and the combinational core. One command completes
// per enabled clock edge. Undefined commands are dropped and reported by a
// registered one-cycle pulse on err. Assumes synchronous active-low reset.
module flag_alu #(
    parameter int DW   = 8,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    cmd,
    input  logic [3:0]    func,
    input  logic [AW-1:0] sel_x,
    input  logic [AW-1:0] sel_y,
    input  logic [DW-1:0] imm,
    input  logic [AW-1:0] dbg_a_sel,
    output logic [DW-1:0] dbg_a_data,
    input  logic [AW-1:0] dbg_b_sel,
    output logic [DW-1:0] dbg_b_data,
    output logic          err
);
    logic [DW-1:0] vx, vy, core_res, core_flg;
    logic          core_res_we, core_flg_we, core_illegal;
    logic          err_q;

    flag_alu_core #(.DW(DW)) u_core (
        .cmd     (cmd),
        .func    (func),
        .opa     (vx),
        .opb     (vy),
        .imm     (imm),
        .res     (core_res),
        .res_we  (core_res_we),
        .flg     (core_flg),
        .flg_we  (core_flg_we),
        .illegal (core_illegal)
    );

    flag_alu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_we   (en & core_res_we),
        .res_addr (sel_x),
        .res_data (core_res),
        .flg_we   (en & core_flg_we),
        .flg_data (core_flg),
        .rd0_addr (sel_x),
        .rd0_data (vx),
        .rd1_addr (sel_y),
        .rd1_data (vy),
        .rd2_addr (dbg_a_sel),
        .rd2_data (dbg_a_data),
        .rd3_addr (dbg_b_sel),
        .rd3_data (dbg_b_data)
    );

    // Error pulse: high for one cycle after an enabled undefined command.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= en & core_illegal;
    end

    assign err = err_q;

endmodule

// File: rtl/flag_alu_checks.sv
// Module: flag_alu_checks
// Property checker bound to flag_alu. It works from the ports, the debug
// reads and the core's flag strobe. Assumes the default 4-bit selectors.
module flag_alu_checks #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [1:0]    cmd,
    input logic [3:0]    func,
    input logic          err,
    input logic [AW-1:0] dbg_a_sel,
    input logic [DW-1:0] dbg_a_data,
    input logic [AW-1:0] dbg_b_sel,
    input logic [DW-1:0] dbg_b_data,
    input logic          flg_we
);
    logic undefined_cmd;
    logic flag_fn;

    // Undefined commands, decoded from the ports.
    assign undefined_cmd = (cmd == 2'b11) ||
                           (cmd == 2'b00 && func > 4'h7 && func != 4'hE);
    // Functions that are allowed to produce a flag.
    assign flag_fn = (cmd == 2'b00) &&
                     (func == 4'h4 || func == 4'h5 || func == 4'h6 ||
                      func == 4'h7 || func == 4'hE);

    // R9: err only follows an enabled undefined command.
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(en && undefined_cmd));

    // R9: an undefined command leaves the watched register unchanged.
    assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en && undefined_cmd) && $stable(dbg_b_sel))
        |-> $stable(dbg_b_data));

    // R10: a disabled cycle leaves the watched register unchanged.
    assert_hold_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en) && $stable(dbg_a_sel)) |-> $stable(dbg_a_data));

    // R8: immediate add never raises the flag strobe.
    assert_addi_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b10) |-> !flg_we);

    // R3: the flag strobe comes only from the flag-producing register functions.
    assert_flag_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flg_we |-> flag_fn);

endmodule

bind flag_alu flag_alu_checks #(.DW(DW), .AW(AW)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cmd        (cmd),
    .func       (func),
    .err        (err),
    .dbg_a_sel  (dbg_a_sel),
    .dbg_a_data (dbg_a_data),
    .dbg_b_sel  (dbg_b_sel),
    .dbg_b_data (dbg_b_data),
    .flg_we     (core_flg_we)
);

// File: tb/flag_alu_bench.sv
// Bench for flag_alu: walks a vector table, then runs directed reset,
// enable, pulse-length and debug-port tests.
module flag_alu_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [3:0] func = 4'h0, sel_x = 4'h0, sel_y = 4'h0;
    logic [7:0] imm = 8'h00;
    logic [3:0] dbg_a_sel = 4'h0, dbg_b_sel = 4'hF;
    logic [7:0] dbg_a_data, dbg_b_data;
    logic       err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    flag_alu u_flag_alu (
        .clk(clk), .rst_n(rst_n), .en(en), .cmd(cmd), .func(func),
        .sel_x(sel_x), .sel_y(sel_y), .imm(imm),
        .dbg_a_sel(dbg_a_sel), .dbg_a_data(dbg_a_data),
        .dbg_b_sel(dbg_b_sel), .dbg_b_data(dbg_b_data), .err(err)
    );

    typedef struct packed {
        logic [1:0] c;
        logic [3:0] f;
        logic [3:0] x;
        logic [3:0] y;
        logic [7:0] im;
        logic [7:0] ax;
        logic [7:0] ay;
        logic [7:0] vf0;
        logic [7:0] ex;
        logic [7:0] ef;
        logic       ee;
        logic [7:0] rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 4'h0, 4'd1, 4'd2, 8'h00, 8'h12, 8'h34, 8'h55, 8'h34, 8'h55, 1'b0, 8'd2}, // R2 copy
        '{2'd0, 4'h1, 4'd1, 4'd2, 8'h00, 8'hF0, 8'h0C, 8'h55, 8'hFC, 8'h55, 1'b0, 8'd2}, // R2 or
        '{2'd0, 4'h2, 4'd1, 4'd2, 8'h00, 8'hF0, 8'h3C, 8'h55, 8'h30, 8'h55, 1'b0, 8'd2}, // R2 and
        '{2'd0, 4'h3, 4'd1, 4'd2, 8'h00, 8'hFF, 8'h0F, 8'h55, 8'hF0, 8'h55, 1'b0, 8'd2}, // R2 xor
        '{2'd0, 4'h4, 4'd1, 4'd2, 8'h00, 8'h80, 8'h7F, 8'h55, 8'hFF, 8'h00, 1'b0, 8'd3}, // R3 no carry
        '{2'd0, 4'h4, 4'd1, 4'd2, 8'h00, 8'h80, 8'h80, 8'h55, 8'h00, 8'h01, 1'b0, 8'd3}, // R3 carry
        '{2'd0, 4'h5, 4'd1, 4'd2, 8'h00, 8'h10, 8'h01, 8'h55, 8'h0F, 8'h01, 1'b0, 8'd4}, // R4 greater
        '{2'd0, 4'h5, 4'd1, 4'd2, 8'h00, 8'h10, 8'h10, 8'h55, 8'h00, 8'h00, 1'b0, 8'd4}, // R4 equal
        '{2'd0, 4'h5, 4'd1, 4'd2, 8'h00, 8'h01, 8'h02, 8'h55, 8'hFF, 8'h00, 1'b0, 8'd4}, // R4 wrap
        '{2'd0, 4'h7, 4'd1, 4'd2, 8'h00, 8'h01, 8'h05, 8'h55, 8'h04, 8'h01, 1'b0, 8'd5}, // R5 greater
        '{2'd0, 4'h7, 4'd1, 4'd2, 8'h00, 8'h20, 8'h20, 8'h55, 8'h00, 8'h00, 1'b0, 8'd5}, // R5 equal
        '{2'd0, 4'h7, 4'd1, 4'd2, 8'h00, 8'h05, 8'h01, 8'h55, 8'hFC, 8'h00, 1'b0, 8'd5}, // R5 wrap
        '{2'd0, 4'h6, 4'd1, 4'd2, 8'h00, 8'h81, 8'hFF, 8'h55, 8'h40, 8'h01, 1'b0, 8'd6}, // R6 shr out 1
        '{2'd0, 4'h6, 4'd1, 4'd2, 8'h00, 8'h02, 8'hFF, 8'h55, 8'h01, 8'h00, 1'b0, 8'd6}, // R6 shr out 0
        '{2'd0, 4'hE, 4'd1, 4'd2, 8'h00, 8'h81, 8'hFF, 8'h55, 8'h02, 8'h01, 1'b0, 8'd6}, // R6 shl out 1
        '{2'd0, 4'hE, 4'd1, 4'd2, 8'h00, 8'h40, 8'hFF, 8'h55, 8'h80, 8'h00, 1'b0, 8'd6}, // R6 shl out 0
        '{2'd0, 4'h4, 4'd15, 4'd2, 8'h00, 8'hF0, 8'h20, 8'hF0, 8'h01, 8'h01, 1'b0, 8'd7}, // R7 add to VF
        '{2'd0, 4'h6, 4'd15, 4'd2, 8'h00, 8'h04, 8'h00, 8'h04, 8'h00, 8'h00, 1'b0, 8'd7}, // R7 shr VF
        '{2'd1, 4'h0, 4'd3, 4'd2, 8'hA5, 8'h00, 8'h00, 8'h55, 8'hA5, 8'h55, 1'b0, 8'd8}, // R8 load
        '{2'd2, 4'h0, 4'd3, 4'd2, 8'h20, 8'hF0, 8'h00, 8'h55, 8'h10, 8'h55, 1'b0, 8'd8}, // R8 add wraps
        '{2'd2, 4'h0, 4'd15, 4'd2, 8'h01, 8'h7F, 8'h00, 8'h7F, 8'h80, 8'h80, 1'b0, 8'd8}, // R8 add to VF
        '{2'd0, 4'h8, 4'd1, 4'd2, 8'h00, 8'h12, 8'h34, 8'h55, 8'h12, 8'h55, 1'b1, 8'd9}, // R9 func 8
        '{2'd0, 4'hF, 4'd1, 4'd2, 8'h00, 8'h12, 8'h34, 8'h55, 8'h12, 8'h55, 1'b1, 8'd9}, // R9 func F
        '{2'd3, 4'h4, 4'd1, 4'd2, 8'h77, 8'h12, 8'h34, 8'h55, 8'h12, 8'h55, 1'b1, 8'd9}  // R9 cmd 11
    };

    task automatic check(input int rq, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    // Apply one enabled command, then return at the following negedge.
    task automatic do_op(input logic [1:0] c, input logic [3:0] f, input logic [3:0] x,
                         input logic [3:0] y, input logic [7:0] im);
        @(negedge clk);
        cmd = c; func = f; sel_x = x; sel_y = y; imm = im; en = 1'b1;
        @(negedge clk);
        en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] r, output logic [7:0] v);
        dbg_a_sel = r;
        #1;
        v = dbg_a_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: all registers zero after reset, err low
        for (int r = 0; r < 16; r++) begin
            rd(r[3:0], v);
            check(1, "reset value", v, 8'h00);
        end
        check(1, "reset err", {7'b0, err}, 8'h00);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            do_op(2'b01, 4'h0, 4'hF, 4'h0, VEC[i].vf0);
            do_op(2'b01, 4'h0, VEC[i].x, 4'h0, VEC[i].ax);
            if (VEC[i].y != VEC[i].x) do_op(2'b01, 4'h0, VEC[i].y, 4'h0, VEC[i].ay);
            do_op(VEC[i].c, VEC[i].f, VEC[i].x, VEC[i].y, VEC[i].im);
            check(int'(VEC[i].rq), $sformatf("vec %0d err", i), {7'b0, err}, {7'b0, VEC[i].ee});
            rd(VEC[i].x, v);
            check(int'(VEC[i].rq), $sformatf("vec %0d Vx", i), v, VEC[i].ex);
            rd(4'hF, v);
            check(int'(VEC[i].rq), $sformatf("vec %0d VF", i), v, VEC[i].ef);
        end

        // R9: err lasts one cycle only
        do_op(2'b11, 4'h0, 4'h1, 4'h2, 8'h00);
        check(9, "err pulse high", {7'b0, err}, 8'h01);
        @(negedge clk);
        check(9, "err pulse ends", {7'b0, err}, 8'h00);

        // R10: disabled command has no effect
        do_op(2'b01, 4'h0, 4'h4, 4'h0, 8'h3C);
        @(negedge clk);
        cmd = 2'b01; sel_x = 4'h4; imm = 8'h99; en = 1'b0;
        repeat (2) @(negedge clk);
        rd(4'h4, v);
        check(10, "disabled write", v, 8'h3C);
        cmd = 2'b11;
        @(negedge clk);
        check(10, "disabled err", {7'b0, err}, 8'h00);

        // R11: debug port follows select with no clock edge
        do_op(2'b01, 4'h0, 4'h5, 4'h0, 8'h5A);
        dbg_b_sel = 4'h4;
        #1;
        check(11, "dbg b select 4", dbg_b_data, 8'h3C);
        dbg_b_sel = 4'h5;
        #1;
        check(11, "dbg b select 5", dbg_b_data, 8'h5A);

        // R1: reset mid-run clears written registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(4'h5, v);
        check(1, "reset clears V5", v, 8'h00);
        rd(4'hF, v);
        check(1, "reset clears VF", v, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule